// File: doc/BRIEF.md
# Six-Word Flash Read Buffer

This block sits between a processor's two read ports and a 32-bit non-volatile memory array. It holds six words, each tagged with its word address. A request whose address is held in the buffer is answered in the same cycle. Any other request starts a single-port array read, and that read takes one cycle, or two when a wait state is in force. The word is written into the buffer, and the request is answered from the buffer in the following cycle. The instruction port has priority over the data port.

Three mode inputs set how the six slots are used. An instruction look-ahead bit fetches the words that follow an instruction miss. A data look-ahead bit does the same for data misses. When both bits are set, the buffer splits into two halves of three words, one half per stream. When one bit or neither is set, all six slots form one shared pool with round-robin replacement. A bypass bit turns off all reuse and all look-ahead, so every request costs the same number of cycles. Any change to these three bits empties the buffer and cancels a read in flight. The wait state is forced on whenever the high-clock-range input is high.

A requester raises its request with a word address and holds both stable until it sees its acknowledge. The data is valid in the acknowledge cycle.

Top module: `flash_read_buffer`

## Requirements
- R1: While reset is asserted, with no request pending, both acknowledges and the memory read strobe are low.
- R2: A request whose word is held in the buffer is acknowledged in its first cycle, and the returned data is the memory word at the requested address.
- R3: A miss with the memory idle drives the read strobe and the miss address at once. The address is held for one cycle with no wait state, or two cycles with one. The acknowledge comes in the cycle after the last read cycle, so the request is answered in its second or third cycle.
- R4: While the high-clock-range input is high, every array read lasts two cycles, whatever the wait-state input says.
- R5: With only instruction look-ahead on, an instruction miss at address A fills the words A+1 to A+5 in the background. Once that finishes, A to A+5 all hit and A+6 misses.
- R6: With only data look-ahead on, a data miss at address A fills the words A+1 to A+5. Once that finishes, data reads of A+1 to A+5 hit and A+6 misses.
- R7: With both look-ahead modes on, each stream keeps three words. After misses at A (instruction) and B (data) and their fills, A+1 and A+2 hit and A+3 misses. The refill caused by the A+3 miss leaves B+1 and B+2 hitting, and B+3 misses.
- R8: With bypass on, no word is reused and no look-ahead read is made. Every request, including a repeat of the same address, takes the full miss time of R3 and R4.
- R9: A change to the bypass bit or to either look-ahead bit empties the buffer. The next request to a previously held address misses.
- R10: When the memory is idle, an instruction miss is served before a data miss, and a data miss is served before any look-ahead read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | Disables reuse and look-ahead |
| cfg_ifetch_ahead | input | 1 | Instruction look-ahead enable |
| cfg_data_ahead | input | 1 | Data look-ahead enable |
| cfg_wait | input | 1 | Adds one wait cycle to each array read |
| fast_clk | input | 1 | High clock range; forces the wait cycle |
| ins_req | input | 1 | Instruction read request, held until acknowledged |
| ins_addr | input | AW | Instruction word address |
| ins_ack | output | 1 | Instruction data valid this cycle |
| ins_rdata | output | DW | Instruction read data |
| dat_req | input | 1 | Data read request, held until acknowledged |
| dat_addr | input | AW | Data word address |
| dat_ack | output | 1 | Data read valid this cycle |
| dat_rdata | output | DW | Data read data |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | AW | Array word address |
| mem_rdata | input | DW | Array read data for mem_addr, valid in the strobe cycle |

## Verification
The assertions check on every clock edge:
- the order in which pending misses are given the memory;
- that a read started under the high clock range holds its address for a second cycle;
- that the cycle after a mode change can acknowledge nothing;
- that bypass mode reads only addresses a requester is asking for.

Capacity and replacement can only be shown by the bench's scenarios. These cover the six-word and three-word windows filled by look-ahead, whether an entry is still present after later misses, and the exact answer times of repeated requests under bypass.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    typedef enum logic [1:0] {
        K_IDEM = 2'd0,
        K_DDEM = 2'd1,
        K_IAHD = 2'd2,
        K_DAHD = 2'd3
    } job_e;

    typedef struct packed {
        logic byp;
        logic iah;
        logic dah;
    } cfg_t;
endpackage

// File: rtl/fbuf_entries.sv
module fbuf_entries #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int N  = 6,
    localparam int IW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [N-1:0]          kill,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [AW-1:0]         wr_tag,
    input  logic [DW-1:0]         wr_dat,
    output logic [N-1:0]          vld,
    output logic [N-1:0][AW-1:0]  tag,
    output logic [N-1:0][DW-1:0]  dat
);
    typedef struct packed {
        logic [N-1:0]         v;
        logic [N-1:0][AW-1:0] t;
        logic [N-1:0][DW-1:0] d;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        s_d.v = s_q.v & ~kill;
        if (wr_en) begin
            s_d.v[wr_idx] = 1'b1;
            s_d.t[wr_idx] = wr_tag;
            s_d.d[wr_idx] = wr_dat;
        end
        if (flush) s_d.v = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vld = s_q.v;
    assign tag = s_q.t;
    assign dat = s_q.d;
endmodule

// File: rtl/fbuf_match.sv
module fbuf_match #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int N  = 6
) (
    input  logic [N-1:0]          vld,
    input  logic [N-1:0][AW-1:0]  tag,
    input  logic [N-1:0][DW-1:0]  dat,
    input  logic [AW-1:0]         addr,
    output logic                  hit,
    output logic [DW-1:0]         rdata
);
    logic [N-1:0] m;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign m[g] = vld[g] && (tag[g] == addr);
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            if (m[k]) rdata = rdata | dat[k];
        end
    end

    assign hit = |m;
endmodule

// File: rtl/flash_read_buffer.sv
module flash_read_buffer import fbuf_pkg::*; #(
    parameter int AW     = 16,
    parameter int DW     = 32,
    parameter int NWORDS = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_bypass,
    input  logic          cfg_ifetch_ahead,
    input  logic          cfg_data_ahead,
    input  logic          cfg_wait,
    input  logic          fast_clk,
    input  logic          ins_req,
    input  logic [AW-1:0] ins_addr,
    output logic          ins_ack,
    output logic [DW-1:0] ins_rdata,
    input  logic          dat_req,
    input  logic [AW-1:0] dat_addr,
    output logic          dat_ack,
    output logic [DW-1:0] dat_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata
);
    localparam int IW   = $clog2(NWORDS);
    localparam int HALF = NWORDS / 2;
    typedef logic [IW-1:0] idx_t;
    localparam idx_t          LAST    = idx_t'(NWORDS - 1);
    localparam idx_t          HBASE   = idx_t'(HALF);
    localparam idx_t          HLAST   = idx_t'(HALF - 1);
    localparam idx_t          ONE_I   = idx_t'(1);
    localparam logic [AW-1:0] ONE_A   = AW'(1);
    localparam logic [NWORDS-1:0] SLOT0 = NWORDS'(1);
    localparam logic [NWORDS-1:0] SLOT1 = NWORDS'(2);

    typedef struct packed {
        logic          busy;
        job_e          kind;
        logic [AW-1:0] addr;
        cfg_t          cfg;
        idx_t          pi;
        idx_t          pd;
        logic [AW-1:0] nai;
        logic [AW-1:0] nad;
        idx_t          lefti;
        idx_t          leftd;
    } ctl_t;

    ctl_t c_d, c_q;

    cfg_t  cfg_now;
    logic  chg, slow, split;
    logic  hit_i, hit_d, hit_a;
    logic  ahead_i_go, ahead_d_go;
    logic [AW-1:0] ahead_addr;
    logic [DW-1:0] rdata_a;
    logic [NWORDS-1:0]         vld, view_i, view_d, kill;
    logic [NWORDS-1:0][AW-1:0] tag;
    logic [NWORDS-1:0][DW-1:0] dat;
    logic          flush, wr_en, go, done, is_ins;
    idx_t          wr_idx;
    job_e          job;
    logic [AW-1:0] jaddr;

    assign cfg_now    = {cfg_bypass, cfg_ifetch_ahead, cfg_data_ahead};
    assign chg        = (cfg_now != c_q.cfg);
    assign slow       = cfg_wait | fast_clk;
    assign split      = cfg_now.iah & cfg_now.dah;
    assign view_i     = cfg_now.byp ? (vld & SLOT0) : vld;
    assign view_d     = cfg_now.byp ? (vld & SLOT1) : vld;
    assign ahead_i_go = !cfg_now.byp && cfg_now.iah && (c_q.lefti != '0);
    assign ahead_d_go = !cfg_now.byp && cfg_now.dah && (c_q.leftd != '0);
    assign ahead_addr = ahead_i_go ? c_q.nai : c_q.nad;

    fbuf_entries #(.AW(AW), .DW(DW), .N(NWORDS)) i_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .kill(kill),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(jaddr), .wr_dat(mem_rdata),
        .vld(vld), .tag(tag), .dat(dat)
    );

    fbuf_match #(.AW(AW), .DW(DW), .N(NWORDS)) i_match_ins (
        .vld(view_i), .tag(tag), .dat(dat), .addr(ins_addr),
        .hit(hit_i), .rdata(ins_rdata)
    );

    fbuf_match #(.AW(AW), .DW(DW), .N(NWORDS)) i_match_dat (
        .vld(view_d), .tag(tag), .dat(dat), .addr(dat_addr),
        .hit(hit_d), .rdata(dat_rdata)
    );

    fbuf_match #(.AW(AW), .DW(DW), .N(NWORDS)) i_match_ahead (
        .vld(vld), .tag(tag), .dat(dat), .addr(ahead_addr),
        .hit(hit_a), .rdata(rdata_a)
    );

    assign ins_ack = ins_req & hit_i;
    assign dat_ack = dat_req & hit_d;

    always_comb begin
        c_d      = c_q;
        c_d.cfg  = cfg_now;
        flush    = 1'b0;
        kill     = '0;
        wr_en    = 1'b0;
        wr_idx   = '0;
        go       = 1'b0;
        done     = 1'b0;
        job      = K_IDEM;
        jaddr    = ins_addr;
        is_ins   = 1'b1;
        if (chg) begin
            flush     = 1'b1;
            c_d.busy  = 1'b0;
            c_d.pi    = '0;
            c_d.pd    = HBASE;
            c_d.lefti = '0;
            c_d.leftd = '0;
        end else begin
            if (cfg_now.byp) begin
                kill[0] = ins_ack;
                kill[1] = dat_ack;
            end
            if (c_q.busy) begin
                go = 1'b1; job = c_q.kind; jaddr = c_q.addr;
            end else if (ins_req && !hit_i) begin
                go = 1'b1; job = K_IDEM; jaddr = ins_addr;
            end else if (dat_req && !hit_d) begin
                go = 1'b1; job = K_DDEM; jaddr = dat_addr;
            end else if (ahead_i_go) begin
                if (hit_a) begin
                    c_d.nai   = c_q.nai + ONE_A;
                    c_d.lefti = c_q.lefti - ONE_I;
                end else begin
                    go = 1'b1; job = K_IAHD; jaddr = c_q.nai;
                end
            end else if (ahead_d_go) begin
                if (hit_a) begin
                    c_d.nad   = c_q.nad + ONE_A;
                    c_d.leftd = c_q.leftd - ONE_I;
                end else begin
                    go = 1'b1; job = K_DAHD; jaddr = c_q.nad;
                end
            end
            done   = go && (c_q.busy || !slow);
            is_ins = (job == K_IDEM) || (job == K_IAHD);
            if (go && !done) begin
                c_d.busy = 1'b1;
                c_d.kind = job;
                c_d.addr = jaddr;
            end
            if (done) begin
                c_d.busy = 1'b0;
                wr_en    = 1'b1;
                if (cfg_now.byp) begin
                    wr_idx = is_ins ? '0 : ONE_I;
                end else if (split && !is_ins) begin
                    wr_idx = c_q.pd;
                    c_d.pd = (c_q.pd == LAST) ? HBASE : c_q.pd + ONE_I;
                end else begin
                    wr_idx = c_q.pi;
                    c_d.pi = (c_q.pi == (split ? HLAST : LAST)) ? '0 : c_q.pi + ONE_I;
                end
                case (job)
                    K_IDEM: if (!cfg_now.byp && cfg_now.iah) begin
                        c_d.nai   = jaddr + ONE_A;
                        c_d.lefti = split ? HLAST : LAST;
                    end
                    K_DDEM: if (!cfg_now.byp && cfg_now.dah) begin
                        c_d.nad   = jaddr + ONE_A;
                        c_d.leftd = split ? HLAST : LAST;
                    end
                    K_IAHD: begin
                        c_d.nai   = c_q.nai + ONE_A;
                        c_d.lefti = c_q.lefti - ONE_I;
                    end
                    default: begin
                        c_d.nad   = c_q.nad + ONE_A;
                        c_d.leftd = c_q.leftd - ONE_I;
                    end
                endcase
            end
        end
    end

    assign mem_rd   = go;
    assign mem_addr = jaddr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.kind  <= K_IDEM;
            c_q.pd    <= HBASE;
        end else begin
            c_q <= c_d;
        end
    end

    // Mode change leaves nothing to hit in the following cycle
    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (!ins_ack && !dat_ack));

    // A read launched in the high clock range keeps its address for a second cycle
    assert_slow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clk && mem_rd && !c_q.busy && !chg)
        |=> (chg || (mem_rd && mem_addr == $past(mem_addr))));

    // Idle memory goes to a pending instruction miss first
    assert_ins_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.busy && !chg && ins_req && !ins_ack) |-> (mem_rd && mem_addr == ins_addr));

    // A data miss beats any look-ahead read
    assert_demand_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_q.busy && !chg && dat_req && !dat_ack && !(ins_req && !ins_ack))
        |-> (mem_rd && mem_addr == dat_addr));

    // Under bypass every array read belongs to a waiting requester
    assert_bypass_demand_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass && !chg && mem_rd)
        |-> ((ins_req && mem_addr == ins_addr) || (dat_req && mem_addr == dat_addr)));
endmodule

// File: tb/test_flash_read_buffer.sv
module test_flash_read_buffer;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byp = 0, iah = 0, dah = 0, wt = 0, fast = 0;
    logic ireq = 0, dreq = 0;
    logic [AW-1:0] iaddr = '0, daddr = '0;
    logic ins_ack, dat_ack, mem_rd;
    logic [DW-1:0] ins_rdata, dat_rdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    assign mem_rdata = word_at(mem_addr);

    flash_read_buffer #(.AW(AW), .DW(DW), .NWORDS(6)) i_flash_read_buffer (
        .clk(clk), .rst_n(rst_n),
        .cfg_bypass(byp), .cfg_ifetch_ahead(iah), .cfg_data_ahead(dah),
        .cfg_wait(wt), .fast_clk(fast),
        .ins_req(ireq), .ins_addr(iaddr), .ins_ack(ins_ack), .ins_rdata(ins_rdata),
        .dat_req(dreq), .dat_addr(daddr), .dat_ack(dat_ack), .dat_rdata(dat_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference data model: every acknowledged word must equal the memory word (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (ins_ack) check(ins_rdata == word_at(iaddr), "R2 ins data", ins_rdata, word_at(iaddr));
            if (dat_ack) check(dat_rdata == word_at(daddr), "R2 dat data", dat_rdata, word_at(daddr));
        end
    end

    task automatic next();
        @(posedge clk); #1;
    endtask

    task automatic settle(input int n);
        repeat (n) next();
    endtask

    task automatic setcfg(input logic b, input logic i, input logic d, input logic w, input logic f);
        byp = b; iah = i; dah = d; wt = w; fast = f;
        settle(2);
    endtask

    task automatic fetch(input bit is_dat, input logic [AW-1:0] a, output int lat);
        lat = -1;
        if (is_dat) begin dreq = 1; daddr = a; end
        else begin ireq = 1; iaddr = a; end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (is_dat ? dat_ack : ins_ack) begin
                lat = k;
                break;
            end
            next();
        end
        next();
        if (is_dat) dreq = 0; else ireq = 0;
    endtask

    task automatic expect_lat(input bit is_dat, input logic [AW-1:0] a, input int exp, input string req);
        int lat;
        fetch(is_dat, a, lat);
        check(lat == exp, req, lat, exp);
    endtask

    initial begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!ins_ack && !dat_ack, "R1 acks in reset", {ins_ack, dat_ack}, 0);
        check(!mem_rd, "R1 read strobe in reset", mem_rd, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        settle(2);

        // R2 R3: shared pool, no look-ahead
        setcfg(0, 0, 0, 0, 0);
        expect_lat(0, 16'd100, 1, "R3 miss no wait");
        expect_lat(0, 16'd100, 0, "R2 hit");
        wt = 1; settle(1);
        expect_lat(0, 16'd110, 2, "R3 miss with wait");
        expect_lat(0, 16'd110, 0, "R2 hit after wait miss");
        expect_lat(1, 16'd100, 0, "R2 data port hits shared word");

        // R4: high clock range forces the wait cycle
        wt = 0; fast = 1; settle(1);
        expect_lat(0, 16'd120, 2, "R4 forced wait");
        fast = 0; settle(1);

        // R5: instruction look-ahead fills six words
        setcfg(0, 1, 0, 1, 0);
        expect_lat(0, 16'd200, 2, "R5 first miss");
        settle(14);
        for (int k = 1; k <= 5; k++) expect_lat(0, 16'(200 + k), 0, "R5 look-ahead hit");
        expect_lat(0, 16'd200, 0, "R5 demand word kept");
        expect_lat(0, 16'd206, 2, "R5 seventh word misses");
        settle(14);

        // R6: data look-ahead fills six words
        setcfg(0, 0, 1, 1, 0);
        expect_lat(1, 16'd300, 2, "R6 first miss");
        settle(14);
        for (int k = 1; k <= 5; k++) expect_lat(1, 16'(300 + k), 0, "R6 look-ahead hit");
        expect_lat(1, 16'd306, 2, "R6 seventh word misses");
        settle(14);

        // R7: split three and three
        setcfg(0, 1, 1, 1, 0);
        expect_lat(0, 16'd400, 2, "R7 ins miss");
        settle(8);
        expect_lat(1, 16'd500, 2, "R7 dat miss");
        settle(8);
        expect_lat(0, 16'd401, 0, "R7 ins ahead 1");
        expect_lat(0, 16'd402, 0, "R7 ins ahead 2");
        expect_lat(0, 16'd403, 2, "R7 ins window is three");
        settle(8);
        expect_lat(1, 16'd501, 0, "R7 dat half untouched 1");
        expect_lat(1, 16'd502, 0, "R7 dat half untouched 2");
        expect_lat(1, 16'd503, 2, "R7 dat window is three");
        settle(8);

        // R9: mode change empties the buffer
        setcfg(0, 0, 0, 0, 0);
        expect_lat(0, 16'd600, 1, "R9 fill");
        expect_lat(0, 16'd600, 0, "R9 hit before change");
        setcfg(0, 0, 1, 0, 0);
        expect_lat(0, 16'd600, 1, "R9 miss after change");

        // R8: bypass, look-ahead bits set but ignored
        setcfg(1, 1, 1, 0, 0);
        expect_lat(0, 16'd700, 1, "R8 bypass read");
        expect_lat(0, 16'd700, 1, "R8 no reuse");
        expect_lat(0, 16'd701, 1, "R8 no look-ahead");
        expect_lat(1, 16'd702, 1, "R8 data bypass read");
        fast = 1; settle(1);
        expect_lat(0, 16'd703, 2, "R8 bypass with forced wait");
        fast = 0; settle(1);

        // R10: instruction miss before data miss
        setcfg(0, 0, 0, 0, 0);
        ireq = 1; iaddr = 16'd800; dreq = 1; daddr = 16'd801;
        @(negedge clk);
        check(mem_rd && mem_addr == 16'd800, "R10 ins served first", mem_addr, 800);
        next();
        @(negedge clk);
        check(ins_ack == 1'b1, "R10 ins ack", ins_ack, 1);
        check(mem_rd && mem_addr == 16'd801, "R10 data follows", mem_addr, 801);
        next(); ireq = 0;
        @(negedge clk);
        check(dat_ack == 1'b1, "R10 data ack", dat_ack, 1);
        next(); dreq = 0;
        settle(2);

        // R10: data miss before instruction look-ahead
        setcfg(0, 1, 0, 1, 0);
        ireq = 1; iaddr = 16'd900; dreq = 1; daddr = 16'd950;
        @(negedge clk);
        check(mem_rd && mem_addr == 16'd900, "R10 ins miss launched", mem_addr, 900);
        next();
        @(negedge clk);
        check(mem_rd && mem_addr == 16'd900, "R3 address held in wait cycle", mem_addr, 900);
        next();
        @(negedge clk);
        check(ins_ack == 1'b1, "R10 ins ack after wait", ins_ack, 1);
        check(mem_rd && mem_addr == 16'd950, "R10 data over look-ahead", mem_addr, 950);
        next(); ireq = 0;
        @(negedge clk);
        check(mem_rd && mem_addr == 16'd950, "R3 data address held", mem_addr, 950);
        next();
        @(negedge clk);
        check(dat_ack == 1'b1, "R10 data ack", dat_ack, 1);
        check(mem_rd && mem_addr == 16'd901, "R5 look-ahead resumes", mem_addr, 901);
        next(); dreq = 0;
        settle(16);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule